// File: doc/BRIEF.md
# Trigger and Location-Monitor Interrupter

This block gathers interrupt causes for a bus module from ten trigger lines and one location-monitor event input. Eight of the trigger lines are of the TTL class and two are of the ECL class. Each trigger line passes through a synchronizer and a rising-edge detector. A captured edge on an unmasked line sets a sticky per-line source bit. Software clears a source bit only by writing a one to it. A second level of state holds two summary bits, one for triggers and one for the location monitor. These summary bits drive an interrupt request at a level that software selects.

An interrupt handler answers the request with an acknowledge strobe. During that cycle the block returns a 16-bit word that holds both summary bits and the module's logical address. That acknowledge, or an ordinary read of the status register, clears the summary bits it returned. An ordinary status read returns all ones in place of the address byte. The control register holds disable bits, all active-high, plus a 3-bit field that selects the level. The register port is a simple single-cycle strobe interface, and its read data is combinational in the strobe cycle.

Top module: `trig_locmon_irq`

## Requirements
- R1: After a synchronous reset, the mask, the source bits and both summary bits are 0, the control register reads 0xFFFF and `irq_lvl` is 0.
- R2: Trigger line i sets source bit i (bits 7:0 are the TTL lines, bits 9:8 the ECL lines). It does so in the third clock edge after the line rises, and only if mask bit i is 1. A line held high sets its bit once, and a line with mask bit 0 sets nothing.
- R3: A write to address 1 clears every source bit written as 1 and leaves bits written as 0 unchanged. A capture in the same edge wins over the clear. A read of address 1 returns the source bits in 9:0, with 15:10 reading 0.
- R4: The trigger summary (status bit 8) is set in any edge that captures a trigger edge. The location summary (status bit 9) is set in any edge where `locmon_evt` is 1. A read of address 3 returns bits 15:10 as 0 and the low byte as 0xFF.
- R5: A status read clears the summary bits it returned. A summary event in the same edge leaves that bit set.
- R6: While `iack` is 1, `reg_rdata` returns {6'b0, location summary, trigger summary, `log_addr`}, taking precedence over `reg_rd`, and the returned summary bits are cleared at that edge.
- R7: Control bit 9 = 1 keeps the location summary from requesting, bit 8 = 1 keeps the trigger summary from requesting, and bit 7 = 1 blocks any request.
- R8: Control bits 5:3 select the level: 000 gives 7, 001 gives 6, and so on down to 110, which gives 1. The value 111 gives no request. `irq_lvl` carries the level, with 0 meaning no request. Control bits 15:10, 6 and 2:0 always read 1.
- R9: `irq_lvl` is registered. It follows the summary bits and the control register of the previous edge, so it drops in the cycle after the enabled summary bits clear.
- R10: Address 0 is the mask. Bits 9:0 are read/write, and bits 15:10 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 mask, 1 source/clear, 2 control, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read or acknowledge data, valid in the strobe cycle |
| ttl_trig | input | 8 | TTL-class trigger lines |
| ecl_trig | input | 2 | ECL-class trigger lines |
| locmon_evt | input | 1 | Location-monitor event, one bit per cycle |
| log_addr | input | 8 | Module logical address |
| iack | input | 1 | Interrupt-acknowledge strobe |
| irq_lvl | output | 3 | Requested level 1..7, 0 for none |

## Verification
The bench targets a write-one-to-clear that lands in the same edge as a capture. A design that let the clear win would silently lose that event. It likewise reads the status register in the same cycle as a location event. A design that cleared every summary bit unconditionally would drop the new event. The bench also issues an acknowledge together with a register read. A design that got the precedence wrong would return the mask instead of the address byte and would not clear the summaries. Finally, the bench holds a trigger line high across a clear, and follows the request level through each disable bit and through the one-cycle drop after an acknowledge. An edge detector that only sampled the level would re-set the source bit. A combinational request would drop a cycle early.

// File: rtl/trg_irq_pkg.sv
package trg_irq_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK   = 2'd0,
        RA_SOURCE = 2'd1,
        RA_CTRL   = 2'd2,
        RA_STATUS = 2'd3
    } reg_addr_e;

    // Control fields kept in flops; other control bits read as one.
    typedef struct packed {
        logic       loc_off;
        logic       trg_off;
        logic       all_off;
        logic [2:0] lvl_sel;
    } ctrl_t;

    typedef struct packed {
        logic loc;
        logic trg;
    } summary_t;

    localparam logic [DATA_W-1:0] CTRL_FILL = 16'hFC47;
    localparam ctrl_t CTRL_RESET = '{loc_off: 1'b1, trg_off: 1'b1, all_off: 1'b1, lvl_sel: 3'b111};

    function automatic logic [2:0] level_of(input logic [2:0] sel);
        return (sel == 3'b111) ? 3'd0 : (3'd7 - sel);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w      = CTRL_FILL;
        w[9]   = c.loc_off;
        w[8]   = c.trg_off;
        w[7]   = c.all_off;
        w[5:3] = c.lvl_sel;
        return w;
    endfunction

    function automatic ctrl_t ctrl_from(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.loc_off = w[9];
        c.trg_off = w[8];
        c.all_off = w[7];
        c.lvl_sel = w[5:3];
        return c;
    endfunction

endpackage

// File: rtl/trig_line_sync.sv
module trig_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/trig_front.sv
module trig_front #(
    parameter int LINES  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] lines,
    output logic [LINES-1:0] rise
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        trig_line_sync #(.STAGES(STAGES)) sync_i (
            .clk (clk),
            .rst (rst),
            .din (lines[i]),
            .rise(rise[i])
        );
    end
endmodule

// File: rtl/irq_sources.sv
module irq_sources import trg_irq_pkg::*; #(
    parameter int LINES = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] rise,
    input  logic [LINES-1:0] mask,
    input  logic             clr_wr,
    input  logic [LINES-1:0] clr_vec,
    input  logic             loc_evt,
    input  logic             ack_clr,
    output logic [LINES-1:0] src_q,
    output summary_t         sum_q
);
    logic [LINES-1:0] captured;
    logic [LINES-1:0] wipe;
    logic             trg_hit;
    summary_t         sum_d;

    always_comb begin
        captured = rise & mask;
        wipe     = clr_wr ? clr_vec : '0;
        trg_hit  = |captured;
        sum_d    = ack_clr ? summary_t'('0) : sum_q;
        if (trg_hit) sum_d.trg = 1'b1;
        if (loc_evt) sum_d.loc = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            sum_q <= '0;
        end else begin
            src_q <= (src_q & ~wipe) | captured;
            sum_q <= sum_d;
        end
    end

    // R3: a source bit only falls where a clear wrote a one
    assert_src_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ((($past(src_q) & ~src_q) & ~$past(wipe)) == '0));

    // R2: a source bit only rises where the mask was one
    assert_mask_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (((src_q & ~$past(src_q)) & ~$past(mask)) == '0));

    // R5: acknowledged trigger summary is gone unless a new capture arrived
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_clr && !trg_hit) |=> !sum_q.trg);

    // R4: a location event always leaves the location summary set
    assert_loc_set_R4: assert property (@(posedge clk) disable iff (rst)
        loc_evt |=> sum_q.loc);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl import trg_irq_pkg::*; #(
    parameter int LINES = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mask_wr,
    input  logic             ctrl_wr,
    input  logic [LINES-1:0] mask_wdata,
    input  ctrl_t            ctrl_wdata,
    input  summary_t         sum,
    output logic [LINES-1:0] mask_q,
    output ctrl_t            ctrl_q,
    output logic [2:0]       irq_lvl
);
    logic       want;
    logic [2:0] lvl_d;

    always_comb begin
        want  = !ctrl_q.all_off &&
                ((sum.trg && !ctrl_q.trg_off) || (sum.loc && !ctrl_q.loc_off));
        lvl_d = want ? level_of(ctrl_q.lvl_sel) : 3'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            ctrl_q  <= CTRL_RESET;
            irq_lvl <= 3'd0;
        end else begin
            if (mask_wr) mask_q <= mask_wdata;
            if (ctrl_wr) ctrl_q <= ctrl_wdata;
            irq_lvl <= lvl_d;
        end
    end

    // R7: global disable forbids a request on the next cycle
    assert_global_off_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.all_off |=> (irq_lvl == 3'd0));

    // R8: selector 111 yields no request
    assert_no_level_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.lvl_sel == 3'b111) |=> (irq_lvl == 3'd0));

    // R9: request drops in the cycle after the summaries are clear
    assert_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (sum == '0) |=> (irq_lvl == 3'd0));
endmodule

// File: rtl/trig_locmon_irq.sv
module trig_locmon_irq import trg_irq_pkg::*; #(
    parameter int TTL_N       = 8,
    parameter int ECL_N       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [TTL_N-1:0]  ttl_trig,
    input  logic [ECL_N-1:0]  ecl_trig,
    input  logic              locmon_evt,
    input  logic [7:0]        log_addr,
    input  logic              iack,
    output logic [2:0]        irq_lvl
);
    localparam int LINES = TTL_N + ECL_N;
    localparam int PAD   = DATA_W - LINES;

    logic [LINES-1:0] rise;
    logic [LINES-1:0] src_q;
    logic [LINES-1:0] mask_q;
    summary_t         sum_q;
    ctrl_t            ctrl_q;
    reg_addr_e        addr;
    logic             mask_wr, clr_wr, ctrl_wr, ack_clr;
    logic             unused_wdata;

    assign addr    = reg_addr_e'(reg_addr);
    assign mask_wr = reg_wr && (addr == RA_MASK);
    assign clr_wr  = reg_wr && (addr == RA_SOURCE);
    assign ctrl_wr = reg_wr && (addr == RA_CTRL);
    assign ack_clr = iack || (reg_rd && (addr == RA_STATUS));
    assign unused_wdata = ^{reg_wdata[DATA_W-1:LINES], reg_wdata[6], reg_wdata[2:0]};

    trig_front #(.LINES(LINES), .STAGES(SYNC_STAGES)) front_i (
        .clk  (clk),
        .rst  (rst),
        .lines({ecl_trig, ttl_trig}),
        .rise (rise)
    );

    irq_sources #(.LINES(LINES)) src_i (
        .clk    (clk),
        .rst    (rst),
        .rise   (rise),
        .mask   (mask_q),
        .clr_wr (clr_wr),
        .clr_vec(reg_wdata[LINES-1:0]),
        .loc_evt(locmon_evt),
        .ack_clr(ack_clr),
        .src_q  (src_q),
        .sum_q  (sum_q)
    );

    irq_ctrl #(.LINES(LINES)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .mask_wr   (mask_wr),
        .ctrl_wr   (ctrl_wr),
        .mask_wdata(reg_wdata[LINES-1:0]),
        .ctrl_wdata(ctrl_from(reg_wdata)),
        .sum       (sum_q),
        .mask_q    (mask_q),
        .ctrl_q    (ctrl_q),
        .irq_lvl   (irq_lvl)
    );

    always_comb begin
        reg_rdata = '0;
        if (iack) begin
            reg_rdata = {6'b0, sum_q.loc, sum_q.trg, log_addr};
        end else if (reg_rd) begin
            unique case (addr)
                RA_MASK:   reg_rdata = {{PAD{1'b0}}, mask_q};
                RA_SOURCE: reg_rdata = {{PAD{1'b0}}, src_q};
                RA_CTRL:   reg_rdata = ctrl_word(ctrl_q);
                RA_STATUS: reg_rdata = {6'b0, sum_q.loc, sum_q.trg, 8'hFF};
                default:   reg_rdata = '0;
            endcase
        end
    end

    // R6: acknowledge word carries the logical address in its low byte
    assert_ack_word_R6: assert property (@(posedge clk) disable iff (rst)
        iack |-> (reg_rdata[7:0] == log_addr));
endmodule

// File: tb/trig_locmon_irq_tb_top.sv
module trig_locmon_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, iack = 1'b0, locmon_evt = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [7:0]  ttl_trig = 8'h0;
    logic [1:0]  ecl_trig = 2'b0;
    logic [7:0]  log_addr = 8'h5A;
    logic [15:0] reg_rdata;
    logic [2:0]  irq_lvl;
    int          n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;

    trig_locmon_irq dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ttl_trig(ttl_trig),
        .ecl_trig(ecl_trig), .locmon_evt(locmon_evt), .log_addr(log_addr),
        .iack(iack), .irq_lvl(irq_lvl)
    );

    // behavioural reference model
    logic [9:0]  m_mask, m_src;
    logic [15:0] m_ctrl;
    logic        m_t, m_l;
    logic [2:0]  m_irq;
    logic [9:0]  hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_mask = 0; m_src = 0; m_ctrl = 16'hFFFF; m_t = 0; m_l = 0; m_irq = 0;
            hist = '{10'h0, 10'h0, 10'h0};
        end else begin
            logic [9:0] cap;
            logic [2:0] sel;
            logic       acc;
            sel = m_ctrl[5:3];
            if (!m_ctrl[7] && ((m_t && !m_ctrl[8]) || (m_l && !m_ctrl[9])) && sel != 3'd7)
                m_irq = 3'd7 - sel;
            else
                m_irq = 3'd0;
            cap = hist[1] & ~hist[0] & m_mask;
            acc = iack || (reg_rd && reg_addr == 2'd3);
            if (reg_wr && reg_addr == 2'd1) m_src = m_src & ~reg_wdata[9:0];
            m_src = m_src | cap;
            if (acc) begin m_t = 0; m_l = 0; end
            if (cap != 0) m_t = 1;
            if (locmon_evt) m_l = 1;
            if (reg_wr && reg_addr == 2'd0) m_mask = reg_wdata[9:0];
            if (reg_wr && reg_addr == 2'd2) m_ctrl = reg_wdata | 16'hFC47;
            void'(hist.pop_front());
            hist.push_back({ecl_trig, ttl_trig});
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rdata();
        if (iack) return {6'b0, m_l, m_t, log_addr};
        if (!reg_rd) return 16'h0;
        case (reg_addr)
            2'd0:    return {6'b0, m_mask};
            2'd1:    return {6'b0, m_src};
            2'd2:    return m_ctrl;
            default: return {6'b0, m_l, m_t, 8'hFF};
        endcase
    endfunction

    // per-clock comparison against the model
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            check("R9 model irq_lvl", {13'b0, irq_lvl}, {13'b0, m_irq});
            if (iack) check("R6 model ack word", reg_rdata, exp_rdata());
            else if (reg_rd) check("R10/R3/R8/R4 model read", reg_rdata, exp_rdata());
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk); reg_rd = 1; reg_addr = a; #2 v = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_loc();
        @(negedge clk); locmon_evt = 1;
        @(negedge clk); locmon_evt = 0;
    endtask

    task automatic chk_irq(string req, logic [2:0] e);
        #2 check(req, {13'b0, irq_lvl}, {13'b0, e});
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1
        rd(2, v); check("R1 ctrl reset", v, 16'hFFFF);
        rd(0, v); check("R1 mask reset", v, 16'h0000);
        rd(1, v); check("R1 source reset", v, 16'h0000);
        rd(3, v); check("R1 status reset", v, 16'h00FF);
        chk_irq("R1 irq reset", 3'd0);
        // R10
        wr(0, 16'hFFFF); rd(0, v); check("R10 mask width", v, 16'h03FF);
        wr(0, 16'h0105);
        // R2
        @(negedge clk); ttl_trig = 8'h07; ecl_trig = 2'b11;
        idle(4); rd(1, v); check("R2 masked capture", v, 16'h0105);
        wr(1, 16'h03FF); idle(4); rd(1, v); check("R2 held level no reset", v, 16'h0000);
        @(negedge clk); ttl_trig = 0; ecl_trig = 0; idle(4);
        @(negedge clk); ttl_trig = 8'h01; idle(4);
        rd(1, v); check("R2 new edge", v, 16'h0001);
        // R3
        wr(1, 16'h0000); rd(1, v); check("R3 zero write no effect", v, 16'h0001);
        wr(1, 16'h0002); rd(1, v); check("R3 other bit no effect", v, 16'h0001);
        wr(1, 16'h0001); rd(1, v); check("R3 one clears", v, 16'h0000);
        // R4 / R5
        rd(3, v); check("R4 trigger summary", v, 16'h01FF);
        rd(3, v); check("R5 read cleared", v, 16'h00FF);
        pulse_loc(); rd(3, v); check("R4 location summary", v, 16'h02FF);
        // R8 / R9
        wr(2, 16'h0000); rd(2, v); check("R8 unused bits read one", v, 16'hFC47);
        chk_irq("R9 no summary no request", 3'd0);
        pulse_loc(); idle(2); chk_irq("R8 level 7", 3'd7);
        wr(2, 16'h0010); idle(1); chk_irq("R8 level 5", 3'd5);
        wr(2, 16'h0038); idle(1); chk_irq("R8 selector 111 none", 3'd0);
        wr(2, 16'h0030); idle(1); chk_irq("R8 level 1", 3'd1);
        // R7
        wr(2, 16'h0230); idle(1); chk_irq("R7 location disabled", 3'd0);
        @(negedge clk); ttl_trig = 0; idle(4);
        @(negedge clk); ttl_trig = 8'h01; idle(4);
        chk_irq("R7 trigger still enabled", 3'd1);
        wr(2, 16'h0330); idle(1); chk_irq("R7 both disabled", 3'd0);
        wr(2, 16'h00B0); idle(1); chk_irq("R7 global disable", 3'd0);
        wr(2, 16'h0030); idle(1); chk_irq("R7 re-enabled", 3'd1);
        // R6 / R9 drop timing
        @(negedge clk); iack = 1; #2 check("R6 ack word", reg_rdata, 16'h035A);
        @(negedge clk); iack = 0; chk_irq("R9 still up one cycle", 3'd1);
        @(negedge clk); chk_irq("R9 dropped", 3'd0);
        rd(3, v); check("R6 ack cleared summaries", v, 16'h00FF);
        // R5 same-cycle event survives
        @(negedge clk); locmon_evt = 1; reg_rd = 1; reg_addr = 2'd3;
        #2 check("R5 returned word", reg_rdata, 16'h00FF);
        @(negedge clk); locmon_evt = 0; reg_rd = 0;
        rd(3, v); check("R5 new event kept", v, 16'h02FF);
        // R6 precedence over read
        pulse_loc();
        @(negedge clk); iack = 1; reg_rd = 1; reg_addr = 2'd0;
        #2 check("R6 ack over read", reg_rdata, 16'h025A);
        @(negedge clk); iack = 0; reg_rd = 0;
        rd(3, v); check("R6 precedence cleared", v, 16'h00FF);
        // R3 capture beats clear in the same edge
        wr(1, 16'h0001);
        @(negedge clk); ttl_trig = 0; idle(4);
        @(negedge clk); ttl_trig = 8'h01;
        @(negedge clk);
        @(negedge clk); reg_wr = 1; reg_addr = 2'd1; reg_wdata = 16'h0001;
        @(negedge clk); reg_wr = 0;
        rd(1, v); check("R3 capture wins over clear", v, 16'h0001);
        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule